// File: doc/BRIEF.md
# Shift-Ones Execute Unit

This is a purely combinational decode-and-execute slice for a 64-bit integer datapath. It looks at one 32-bit instruction word and decides whether the word belongs to the shift-ones group. If it does, the slice computes the result from two 64-bit source operands in the same cycle. A shift-ones operation works like a logical shift, but every bit position that the shift empties is filled with 1 instead of 0. The slice builds this by inverting the operand, shifting it logically and inverting the outcome.

The group has eight members. Each one is a choice of direction (toward the most significant bit or toward the least significant bit), shift source (the low bits of the second operand, or an immediate field of the instruction) and width (the full 64 bits, or a 32-bit word whose result is sign-extended). An enable input tells the slice whether the bit-manipulation extension is switched on. When it is off, a matching encoding is reported as illegal. Encodings that do not match leave both flags low, so that other execute units can claim them. The slice holds no state. A surrounding pipeline samples its outputs in whatever stage it is placed.

Top module: `shift_ones_unit`

## Requirements
- R1: With opcode bits [6:0] = 0110011, bits [31:25] = 0010000 and bits [14:12] = 001, and with the enable high, `res_valid` is 1 and `res_data` = NOT((NOT src_a) << src_b[5:0]).
- R2: With the same opcode and funct7 as R1 but bits [14:12] = 101, and with the enable high, `res_valid` is 1 and `res_data` = NOT((NOT src_a) >> src_b[5:0]), using a logical shift.
- R3: Word register forms use opcode 0111011, funct7 0010000, and the same funct3 codes as R1 and R2 (001 for left, 101 for right). They use only src_a[31:0] and src_b[4:0]. The 32-bit ones-filled result is sign-extended from its bit 31, so res_data[63:32] all equal res_data[31].
- R4: Immediate full-width forms use opcode 0010011 with bits [31:26] = 001000. The 6-bit shift amount is taken from bits [25:20]. Bits [14:12] = 001 shifts left and 101 shifts right.
- R5: Immediate word forms use opcode 0011011 with bits [31:25] = 0010000. The 5-bit shift amount is taken from bits [24:20], the direction codes are the same as in R4, and the result is sign-extended as in R3.
- R6: With the enable low, any encoding accepted by R1 to R5 gives `res_illegal` = 1, `res_valid` = 0 and `res_data` = 0. `res_illegal` is never 1 while the enable is high.
- R7: An instruction word that no rule from R1 to R5 accepts gives `res_valid` = 0, `res_illegal` = 0 and `res_data` = 0. This covers a wrong funct7, a wrong funct6, funct3 = 000 and an unrelated opcode. Whenever `res_valid` is 0, `res_data` is 0.
- R8: A shift amount of zero returns src_a unchanged in full-width forms, and the sign-extended src_a[31:0] in word forms. With a zero operand, the maximum amount gives 64'h7FFF_FFFF_FFFF_FFFF (left, full), 64'hFFFF_FFFF_FFFF_FFFE (right, full), 64'h0000_0000_7FFF_FFFF (left, word) and 64'hFFFF_FFFF_FFFF_FFFE (right, word).
- R9: `res_valid` and `res_illegal` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to decode |
| src_a | input | 64 | First source operand (value to shift) |
| src_b | input | 64 | Second source operand; its low bits give the shift amount in register forms |
| ext_on | input | 1 | Bit-manipulation extension enabled |
| res_valid | output | 1 | The instruction is a shift-ones operation and the result is valid |
| res_illegal | output | 1 | The instruction is a shift-ones operation but the extension is disabled |
| res_data | output | 64 | Result, or 0 when not valid |

## Verification
The checker's properties assume that every input is a known value. They are evaluated only when the instruction, operands and enable carry no X or Z, because a real issue stage may present garbage on idle cycles. The bench always drives fully defined words. It drives them half a clock period before each sample, so every combinational check sees settled inputs. Register-form operands carry deliberately non-zero upper bits in src_b. This lets the sweep confirm that only the low five or six bits decide the shift amount.

// File: rtl/so_pkg.sv
package so_pkg;

    localparam logic [6:0] OPC_REG      = 7'b0110011;
    localparam logic [6:0] OPC_REG_WORD = 7'b0111011;
    localparam logic [6:0] OPC_IMM      = 7'b0010011;
    localparam logic [6:0] OPC_IMM_WORD = 7'b0011011;

    localparam logic [6:0] FN7_ONES = 7'b0010000;
    localparam logic [5:0] FN6_ONES = 6'b001000;

    localparam logic [2:0] FN3_LEFT  = 3'b001;
    localparam logic [2:0] FN3_RIGHT = 3'b101;

    typedef enum logic [1:0] {
        FORM_REG      = 2'd0,
        FORM_IMM      = 2'd1,
        FORM_REG_WORD = 2'd2,
        FORM_IMM_WORD = 2'd3
    } so_form_e;

    typedef struct packed {
        logic     hit;
        logic     to_right;
        so_form_e form;
    } so_dec_t;

endpackage

// File: rtl/so_decode.sv
module so_decode
    import so_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output so_dec_t    dec
);

    logic dir_ok;

    always_comb begin
        dir_ok = (funct3 == FN3_LEFT) || (funct3 == FN3_RIGHT);
        dec          = '0;
        dec.to_right = (funct3 == FN3_RIGHT);
        dec.form     = FORM_REG;
        unique case (opcode)
            OPC_REG: begin
                dec.form = FORM_REG;
                dec.hit  = dir_ok && (funct7 == FN7_ONES);
            end
            OPC_REG_WORD: begin
                dec.form = FORM_REG_WORD;
                dec.hit  = dir_ok && (funct7 == FN7_ONES);
            end
            OPC_IMM: begin
                dec.form = FORM_IMM;
                dec.hit  = dir_ok && (funct7[6:1] == FN6_ONES);
            end
            OPC_IMM_WORD: begin
                dec.form = FORM_IMM_WORD;
                dec.hit  = dir_ok && (funct7 == FN7_ONES);
            end
            default: begin
                dec.hit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/so_amount.sv
module so_amount
    import so_pkg::*;
#(
    parameter int SHW = 6
) (
    input  so_form_e           form,
    input  logic [SHW-1:0]     imm_amt,
    input  logic [SHW-1:0]     reg_amt,
    output logic [SHW-1:0]     amt
);

    localparam logic [SHW-1:0] WORD_MASK = {1'b0, {(SHW-1){1'b1}}};

    always_comb begin
        unique case (form)
            FORM_REG:      amt = reg_amt;
            FORM_IMM:      amt = imm_amt;
            FORM_REG_WORD: amt = reg_amt & WORD_MASK;
            FORM_IMM_WORD: amt = imm_amt & WORD_MASK;
            default:       amt = '0;
        endcase
    end

endmodule

// File: rtl/so_core.sv
module so_core #(
    parameter int XLEN = 64,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] opnd,
    input  logic [SHW-1:0]  amt,
    input  logic            to_right,
    input  logic            word,
    output logic [XLEN-1:0] result
);

    localparam int WW = XLEN / 2;

    logic [XLEN-1:0] inv_full;
    logic [XLEN-1:0] full_res;
    logic [XLEN-1:0] word_res;

    always_comb begin
        inv_full = ~opnd;
        if (to_right) full_res = ~(inv_full >> amt);
        else          full_res = ~(inv_full << amt);
    end

    generate
        if (XLEN >= 64) begin : g_word
            logic [WW-1:0] inv_w;
            logic [WW-1:0] w_res;
            always_comb begin
                inv_w = ~opnd[WW-1:0];
                if (to_right) w_res = ~(inv_w >> amt[SHW-2:0]);
                else          w_res = ~(inv_w << amt[SHW-2:0]);
                word_res = {{(XLEN-WW){w_res[WW-1]}}, w_res};
            end
        end else begin : g_noword
            assign word_res = full_res;
        end
    endgenerate

    assign result = word ? word_res : full_res;

endmodule

// File: rtl/shift_ones_unit.sv
module shift_ones_unit
    import so_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int ILEN = 32
) (
    input  logic [ILEN-1:0] instr,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic            ext_on,
    output logic            res_valid,
    output logic            res_illegal,
    output logic [XLEN-1:0] res_data
);

    localparam int SHW = $clog2(XLEN);

    so_dec_t          dec;
    logic [SHW-1:0]   amt;
    logic [XLEN-1:0]  core_res;
    logic             is_word;

    so_decode u_dec (
        .opcode (instr[6:0]),
        .funct3 (instr[14:12]),
        .funct7 (instr[31:25]),
        .dec    (dec)
    );

    so_amount #(.SHW(SHW)) u_amt (
        .form    (dec.form),
        .imm_amt (instr[20+SHW-1:20]),
        .reg_amt (src_b[SHW-1:0]),
        .amt     (amt)
    );

    assign is_word = (dec.form == FORM_REG_WORD) || (dec.form == FORM_IMM_WORD);

    so_core #(.XLEN(XLEN), .SHW(SHW)) u_core (
        .opnd     (src_a),
        .amt      (amt),
        .to_right (dec.to_right),
        .word     (is_word),
        .result   (core_res)
    );

    always_comb begin
        res_valid   = dec.hit && ext_on;
        res_illegal = dec.hit && !ext_on;
        res_data    = res_valid ? core_res : '0;
    end

endmodule

// File: rtl/so_checker.sv
module so_checker #(
    parameter int XLEN = 64,
    parameter int ILEN = 32
) (
    input logic [ILEN-1:0] instr,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic            ext_on,
    input logic            res_valid,
    input logic            res_illegal,
    input logic [XLEN-1:0] res_data
);

    localparam int SHW = $clog2(XLEN);

    logic            known;
    logic            word_op;
    logic            left_op;
    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] low_mask;

    always_comb begin
        known    = !$isunknown({instr, src_a, src_b, ext_on});
        word_op  = instr[3];
        left_op  = (instr[14:12] == 3'b001);
        shamt    = instr[5] ? src_b[SHW-1:0] : instr[20+SHW-1:20];
        low_mask = ({{(XLEN-1){1'b0}}, 1'b1} << shamt) - 1'b1;
        if (known) begin
            AST_EXCLUSIVE_FLAGS: assert (!(res_valid && res_illegal)); // R9
            AST_IDLE_ZERO: assert (res_valid || res_data == '0); // R7
            AST_ILLEGAL_ONLY_OFF: assert (!res_illegal || !ext_on); // R6
            AST_OFF_NO_VALID: assert (ext_on || !res_valid); // R6
            AST_WORD_SIGNEXT: assert (!(res_valid && word_op) || res_data[XLEN-1:XLEN/2] == {(XLEN/2){res_data[XLEN/2-1]}}); // R3
            AST_ZERO_SHIFT: assert (!(res_valid && !word_op && shamt == '0) || res_data == src_a); // R8
            AST_LEFT_FILL: assert (!(res_valid && !word_op && left_op) || (res_data & low_mask) == low_mask); // R1
        end
    end

endmodule

bind shift_ones_unit so_checker #(.XLEN(XLEN), .ILEN(ILEN)) u_chk (
    .instr       (instr),
    .src_a       (src_a),
    .src_b       (src_b),
    .ext_on      (ext_on),
    .res_valid   (res_valid),
    .res_illegal (res_illegal),
    .res_data    (res_data)
);

// File: tb/test_shift_ones_unit.sv
module test_shift_ones_unit;

    logic        clk = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        ext_on = 1'b0;
    logic        res_valid;
    logic        res_illegal;
    logic [63:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    shift_ones_unit i_shift_ones_unit (
        .instr       (instr),
        .src_a       (src_a),
        .src_b       (src_b),
        .ext_on      (ext_on),
        .res_valid   (res_valid),
        .res_illegal (res_illegal),
        .res_data    (res_data)
    );

    function automatic logic [63:0] pat(input int i);
        case (i)
            0: pat = 64'h0;
            1: pat = 64'hFFFF_FFFF_FFFF_FFFF;
            2: pat = 64'h8000_0000_0000_0001;
            3: pat = 64'h0123_4567_89AB_CDEF;
            4: pat = 64'hFEDC_BA98_7654_3210;
            default: pat = 64'h0000_0000_7FFF_FFFE;
        endcase
    endfunction

    function automatic logic [31:0] enc(input int form, input bit right, input int s);
        logic [2:0] f3;
        logic [5:0] s6;
        f3 = right ? 3'b101 : 3'b001;
        s6 = s[5:0];
        case (form)
            0: enc = {7'b0010000, 5'd2, 5'd1, f3, 5'd3, 7'b0110011};
            1: enc = {6'b001000, s6, 5'd1, f3, 5'd3, 7'b0010011};
            2: enc = {7'b0010000, 5'd2, 5'd1, f3, 5'd3, 7'b0111011};
            default: enc = {7'b0010000, s6[4:0], 5'd1, f3, 5'd3, 7'b0011011};
        endcase
    endfunction

    // Fill-with-ones expressed as shift plus OR of a ones mask
    function automatic logic [63:0] model(input int form, input bit right, input int s, input logic [63:0] a);
        logic [5:0]  s6;
        logic [4:0]  s5;
        logic [31:0] w;
        s6 = s[5:0];
        s5 = s[4:0];
        if (form < 2) begin
            if (right) model = (a >> s6) | ~(64'hFFFF_FFFF_FFFF_FFFF >> s6);
            else       model = (a << s6) | ((64'd1 << s6) - 64'd1);
        end else begin
            if (right) w = (a[31:0] >> s5) | ~(32'hFFFF_FFFF >> s5);
            else       w = (a[31:0] << s5) | ((32'd1 << s5) - 32'd1);
            model = {{32{w[31]}}, w};
        end
    endfunction

    task automatic apply(input logic [31:0] i, input logic [63:0] a, input logic [63:0] b, input logic en);
        @(posedge clk);
        instr  = i;
        src_a  = a;
        src_b  = b;
        ext_on = en;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic ev, input logic ei, input logic [63:0] ed);
        n_checks++;
        if (res_valid !== ev || res_illegal !== ei || res_data !== ed) begin
            n_fail++;
            $display("FAIL %s: instr=%h got v=%b i=%b d=%h expected v=%b i=%b d=%h",
                     req, instr, res_valid, res_illegal, res_data, ev, ei, ed);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        string tag;
        int    smax;
        // reset-like idle state: zero instruction
        apply(32'h0, 64'h0, 64'h0, 1'b0);
        check("R7 idle", 1'b0, 1'b0, 64'h0);

        // main sweep over forms, directions, amounts and operands
        for (int form = 0; form < 4; form++) begin
            for (int dir = 0; dir < 2; dir++) begin
                smax = (form == 3) ? 32 : 64;
                for (int s = 0; s < smax; s++) begin
                    for (int p = 0; p < 6; p++) begin
                        case (form)
                            0: tag = (dir == 1) ? "R2" : "R1";
                            1: tag = "R4";
                            2: tag = "R3";
                            default: tag = "R5";
                        endcase
                        apply(enc(form, dir[0], s), pat(p),
                              {pat(5 - p)[63:6], s[5:0]}, 1'b1);
                        check(tag, 1'b1, 1'b0, model(form, dir[0], s, pat(p)));
                    end
                end
            end
        end

        // R8 boundary amounts
        apply(enc(1, 1'b0, 0), 64'h0123_4567_89AB_CDEF, 64'h0, 1'b1);
        check("R8 zero full", 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF);
        apply(enc(3, 1'b1, 0), 64'h0123_4567_89AB_CDEF, 64'h0, 1'b1);
        check("R8 zero word", 1'b1, 1'b0, 64'hFFFF_FFFF_89AB_CDEF);
        apply(enc(1, 1'b0, 63), 64'h0, 64'h0, 1'b1);
        check("R8 max left full", 1'b1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF);
        apply(enc(1, 1'b1, 63), 64'h0, 64'h0, 1'b1);
        check("R8 max right full", 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE);
        apply(enc(3, 1'b0, 31), 64'h0, 64'h0, 1'b1);
        check("R8 max left word", 1'b1, 1'b0, 64'h0000_0000_7FFF_FFFF);
        apply(enc(2, 1'b1, 0), 64'h0, 64'hFFFF_FFFF_FFFF_FFDF, 1'b1);
        check("R8 max right word", 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE);

        // R6 extension off: every form, both directions
        for (int form = 0; form < 4; form++) begin
            for (int dir = 0; dir < 2; dir++) begin
                apply(enc(form, dir[0], 7), 64'h0123_4567_89AB_CDEF, 64'd7, 1'b0);
                check("R6 disabled", 1'b0, 1'b1, 64'h0);
                if (res_valid && res_illegal) begin
                    n_fail++;
                    $display("FAIL R9: both flags high, expected at most one");
                end
                n_checks++;
            end
        end

        // R7 non-matching encodings, enable high and low
        for (int en = 0; en < 2; en++) begin
            apply({7'b0000000, 5'd2, 5'd1, 3'b001, 5'd3, 7'b0110011}, 64'h5, 64'h3, en[0]);
            check("R7 funct7", 1'b0, 1'b0, 64'h0);
            apply({7'b0010000, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011}, 64'h5, 64'h3, en[0]);
            check("R7 funct3", 1'b0, 1'b0, 64'h0);
            apply({6'b010000, 6'd3, 5'd1, 3'b101, 5'd3, 7'b0010011}, 64'h5, 64'h3, en[0]);
            check("R7 funct6", 1'b0, 1'b0, 64'h0);
            apply({7'b0010001, 5'd3, 5'd1, 3'b001, 5'd3, 7'b0011011}, 64'h5, 64'h3, en[0]);
            check("R7 word imm bit25", 1'b0, 1'b0, 64'h0);
            apply({7'b0010000, 5'd2, 5'd1, 3'b001, 5'd3, 7'b0110111}, 64'h5, 64'h3, en[0]);
            check("R7 opcode", 1'b0, 1'b0, 64'h0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule